// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a load or store and, when the addressing mode calls for it, the updated value of the base register. It takes a base value and builds an offset from one of three sources: a 12-bit immediate, an index register, or an index register shifted left by 0 to 3 places. It then adds the offset to the base or subtracts it from the base. The addressing mode decides how the result is used. In offset mode the result is the address and the base is left alone. In pre-indexed mode the result is the address and is also written back. In post-indexed mode the original base is the address and the result is written back.

An execute stage presents one request per cycle with `req_valid`. The block registers its results, so they appear one clock later together with a one-cycle `rsp_valid` pulse. They hold their values until the next request. All arithmetic wraps modulo 2^32 and no overflow is reported.

Top module: `agu_ldst_addr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_addr`, `rsp_base` and `rsp_wb` are all cleared to zero at that edge.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. Outputs change only on a clock edge where `req_valid` is high, and otherwise keep their values.
- R3: With `req_mode` = 2'b00 (offset), `rsp_addr` = base ± offset, `rsp_wb` = 0 and `rsp_base` equals the unmodified base.
- R4: With `req_mode` = 2'b01 (pre-indexed), `rsp_addr` = base ± offset, `rsp_base` equals that same value, and `rsp_wb` = 1.
- R5: With `req_mode` = 2'b10 (post-indexed), `rsp_addr` equals the unmodified base, `rsp_base` = base ± offset, and `rsp_wb` = 1.
- R6: `req_mode` = 2'b11 gives exactly the results of offset mode.
- R7: `req_osrc` selects the offset: 2'b00 is the immediate, zero-extended to 32 bits; 2'b01 is the index register; 2'b10 is the index register shifted left by `req_shamt`; 2'b11 is the index register unshifted.
- R8: The left shift discards bits moved beyond bit 31 and fills the vacated low bits with zeros.
- R9: `req_sub` = 0 adds the offset to the base and `req_sub` = 1 subtracts it. Both results wrap modulo 2^32 with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_base | input | 32 | Base register value |
| req_osrc | input | 2 | Offset source select |
| req_imm | input | 12 | Immediate offset |
| req_index | input | 32 | Index register value |
| req_shamt | input | 2 | Left-shift amount for the index |
| req_sub | input | 1 | 1 = subtract offset, 0 = add |
| req_mode | input | 2 | Addressing mode |
| rsp_valid | output | 1 | One-cycle pulse: results updated |
| rsp_addr | output | 32 | Effective address |
| rsp_base | output | 32 | New base value |
| rsp_wb | output | 1 | Base writeback enable |

## Verification
The assertions assume that every request input is driven to a known value in any cycle where `req_valid` is high. They also assume that `req_valid` is held low while reset is applied, because the mode and writeback properties compare the registered outputs against `$past` of the request inputs. The bench meets both assumptions. It holds `req_valid` low during reset, drives every request field on the falling clock edge before asserting `req_valid`, and changes the request fields only while `req_valid` is low when it checks that the outputs hold their values.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the load/store address generator.
// Assumes 2-bit mode and offset-source fields on the request interface.
package agu_pkg;

    // Addressing mode; the reserved code behaves like plain offset mode
    typedef enum logic [1:0] {
        AM_OFFSET = 2'b00,
        AM_PRE    = 2'b01,
        AM_POST   = 2'b10,
        AM_RSVD   = 2'b11
    } amode_e;

    // Offset source; the reserved code selects the unshifted index
    typedef enum logic [1:0] {
        OS_IMM    = 2'b00,
        OS_IDX    = 2'b01,
        OS_IDX_SH = 2'b10,
        OS_RSVD   = 2'b11
    } osrc_e;

endpackage

// File: rtl/agu_offset_gen.sv
// Module: agu_offset_gen
// Builds the offset operand from the immediate (zero-extended), the index,
// or the index shifted left through a log-stage barrel shifter.
// Assumes IMMW <= AW. Bits shifted past the top are discarded.
module agu_offset_gen
    import agu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IMMW = 12,
    parameter int SHW  = 2
) (
    input  logic [1:0]      osrc,
    input  logic [IMMW-1:0] imm,
    input  logic [AW-1:0]   index,
    input  logic [SHW-1:0]  shamt,
    output logic [AW-1:0]   offset
);
    localparam int PADW = AW - IMMW;

    logic [AW-1:0] stage [0:SHW];
    logic [AW-1:0] imm_ext;

    assign stage[0] = index;
    assign imm_ext  = {{PADW{1'b0}}, imm};

    // one shifter stage per shift-amount bit, each moving by 2**k places
    genvar k;
    generate
        for (k = 0; k < SHW; k++) begin : g_shift
            assign stage[k+1] = shamt[k] ? (stage[k] << (2**k)) : stage[k];
        end
    endgenerate

    // pick the offset source
    always_comb begin
        case (osrc_e'(osrc))
            OS_IMM:    offset = imm_ext;
            OS_IDX_SH: offset = stage[SHW];
            default:   offset = index;
        endcase
    end

endmodule

// File: rtl/agu_addsub.sv
// Module: agu_addsub
// Adds or subtracts the offset from the base, wrapping modulo 2**AW.
// Assumes no carry or overflow reporting is needed.
module agu_addsub #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          sub,
    output logic [AW-1:0] result
);
    // two's-complement add or subtract, truncated to AW bits
    always_comb begin
        if (sub) result = base - offset;
        else     result = base + offset;
    end

endmodule

// File: rtl/agu_mode_sel.sv
// Module: agu_mode_sel
// Routes the base and the indexed sum to address and writeback outputs
// according to the addressing mode. Without writeback, the new base is the
// unmodified base. Assumes the reserved mode behaves like offset mode.
module agu_mode_sel
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] sum,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] new_base,
    output logic          wb
);
    // per-mode selection of address, writeback value and enable
    always_comb begin
        case (amode_e'(mode))
            AM_PRE: begin
                addr     = sum;
                new_base = sum;
                wb       = 1'b1;
            end
            AM_POST: begin
                addr     = base;
                new_base = sum;
                wb       = 1'b1;
            end
            default: begin
                addr     = sum;
                new_base = base;
                wb       = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/agu_ldst_addr.sv
// Module: agu_ldst_addr (top)
// Load/store address generation with a registered output stage. A request
// qualified by req_valid is captured at the clock edge. rsp_valid pulses in
// the next cycle, and the results hold until the next request.
// Assumes synchronous active-low reset and request fields valid with req_valid.
module agu_ldst_addr #(
    parameter int AW   = 32,
    parameter int IMMW = 12,
    parameter int SHW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_base,
    input  logic [1:0]      req_osrc,
    input  logic [IMMW-1:0] req_imm,
    input  logic [AW-1:0]   req_index,
    input  logic [SHW-1:0]  req_shamt,
    input  logic            req_sub,
    input  logic [1:0]      req_mode,
    output logic            rsp_valid,
    output logic [AW-1:0]   rsp_addr,
    output logic [AW-1:0]   rsp_base,
    output logic            rsp_wb
);
    logic [AW-1:0] offset;
    logic [AW-1:0] sum;
    logic [AW-1:0] nx_addr;
    logic [AW-1:0] nx_base;
    logic          nx_wb;

    agu_offset_gen #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
        .osrc   (req_osrc),
        .imm    (req_imm),
        .index  (req_index),
        .shamt  (req_shamt),
        .offset (offset)
    );

    agu_addsub #(.AW(AW)) u_add (
        .base   (req_base),
        .offset (offset),
        .sub    (req_sub),
        .result (sum)
    );

    agu_mode_sel #(.AW(AW)) u_mode (
        .mode     (req_mode),
        .base     (req_base),
        .sum      (sum),
        .addr     (nx_addr),
        .new_base (nx_base),
        .wb       (nx_wb)
    );

    // valid pulse: one cycle per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // result registers: load on a request, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_base <= '0;
            rsp_wb   <= 1'b0;
        end else if (req_valid) begin
            rsp_addr <= nx_addr;
            rsp_base <= nx_base;
            rsp_wb   <= nx_wb;
        end
    end

endmodule

// File: rtl/agu_ldst_addr_chk.sv
// Module: agu_ldst_addr_chk
// Temporal checks on the address generator's ports, bound to every instance.
// Assumes req_valid is held low during reset.
module agu_ldst_addr_chk #(
    parameter int AW   = 32,
    parameter int IMMW = 12,
    parameter int SHW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [AW-1:0]   req_base,
    input logic [1:0]      req_osrc,
    input logic [IMMW-1:0] req_imm,
    input logic [AW-1:0]   req_index,
    input logic [SHW-1:0]  req_shamt,
    input logic            req_sub,
    input logic [1:0]      req_mode,
    input logic            rsp_valid,
    input logic [AW-1:0]   rsp_addr,
    input logic [AW-1:0]   rsp_base,
    input logic            rsp_wb
);
    localparam int PADW = AW - IMMW;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && rsp_addr == '0 && rsp_base == '0 && !rsp_wb)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_addr) && $stable(rsp_base) && $stable(rsp_wb))); // R2

    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b00) |=> (!rsp_wb && rsp_base == $past(req_base))); // R3

    AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01) |=> (rsp_wb && rsp_addr == rsp_base)); // R4

    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b10) |=> (rsp_wb && rsp_addr == $past(req_base))); // R5

    AST_RSVD_AS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b11) |=> (!rsp_wb && rsp_base == $past(req_base))); // R6

    AST_IMM_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b01 && req_osrc == 2'b00 && !req_sub)
        |=> (rsp_base == $past(req_base) + {{PADW{1'b0}}, $past(req_imm)})); // R7

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'b10 && req_osrc == 2'b01 && req_sub)
        |=> (rsp_base == $past(req_base) - $past(req_index))); // R9

endmodule

bind agu_ldst_addr agu_ldst_addr_chk #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_base  (req_base),
    .req_osrc  (req_osrc),
    .req_imm   (req_imm),
    .req_index (req_index),
    .req_shamt (req_shamt),
    .req_sub   (req_sub),
    .req_mode  (req_mode),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_base  (rsp_base),
    .rsp_wb    (rsp_wb)
);

// File: tb/sim_agu_ldst_addr.sv
// Directed bench for agu_ldst_addr: one task per scenario, each self-checking.
module sim_agu_ldst_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_base = '0;
    logic [1:0]  req_osrc = '0;
    logic [11:0] req_imm = '0;
    logic [31:0] req_index = '0;
    logic [1:0]  req_shamt = '0;
    logic        req_sub = 1'b0;
    logic [1:0]  req_mode = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [31:0] rsp_base;
    logic        rsp_wb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    agu_ldst_addr u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_osrc(req_osrc), .req_imm(req_imm), .req_index(req_index),
        .req_shamt(req_shamt), .req_sub(req_sub), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_base(rsp_base),
        .rsp_wb(rsp_wb)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // expected offset from the R7/R8 encoding rules
    function automatic logic [31:0] exp_off(input logic [1:0] s, input logic [11:0] im,
                                            input logic [31:0] ix, input logic [1:0] sh);
        case (s)
            2'b00:   return {20'd0, im};
            2'b10:   return ix << sh;
            default: return ix;
        endcase
    endfunction

    // one request, then sample the registered response at the next falling edge
    task automatic issue(input logic [31:0] b, input logic [1:0] s, input logic [11:0] im,
                         input logic [31:0] ix, input logic [1:0] sh, input logic sb,
                         input logic [1:0] md);
        @(negedge clk);
        req_base = b; req_osrc = s; req_imm = im; req_index = ix;
        req_shamt = sh; req_sub = sb; req_mode = md; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // issue and compare against an expectation derived from R3..R6
    task automatic run_op(input string req, input logic [31:0] b, input logic [1:0] s,
                          input logic [11:0] im, input logic [31:0] ix, input logic [1:0] sh,
                          input logic sb, input logic [1:0] md);
        logic [31:0] o, sum, ea, nb;
        logic wb;
        o   = exp_off(s, im, ix, sh);
        sum = sb ? b - o : b + o;
        case (md)
            2'b01:   begin ea = sum; nb = sum; wb = 1'b1; end
            2'b10:   begin ea = b;   nb = sum; wb = 1'b1; end
            default: begin ea = sum; nb = b;   wb = 1'b0; end
        endcase
        issue(b, s, im, ix, sh, sb, md);
        chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        chk(req, "rsp_addr", rsp_addr, ea);
        chk(req, "rsp_base", rsp_base, nb);
        chk(req, "rsp_wb", {31'd0, rsp_wb}, {31'd0, wb});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "rsp_addr", rsp_addr, 32'd0);
        chk("R1", "rsp_base", rsp_base, 32'd0);
        chk("R1", "rsp_wb", {31'd0, rsp_wb}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_offset_mode();
        run_op("R3", 32'h2000_0000, 2'b00, 12'h010, 32'h0, 2'd0, 1'b0, 2'b00);
        run_op("R3", 32'h2000_0100, 2'b01, 12'h000, 32'h40, 2'd0, 1'b1, 2'b00);
    endtask

    task automatic t_pre_mode();
        run_op("R4", 32'h1000_0000, 2'b00, 12'h004, 32'h0, 2'd0, 1'b0, 2'b01);
        run_op("R4", 32'h1000_0000, 2'b10, 12'h000, 32'h3, 2'd2, 1'b1, 2'b01);
    endtask

    task automatic t_post_mode();
        run_op("R5", 32'h0000_8000, 2'b00, 12'h008, 32'h0, 2'd0, 1'b0, 2'b10);
        run_op("R5", 32'h0000_8000, 2'b01, 12'h000, 32'h100, 2'd0, 1'b1, 2'b10);
    endtask

    task automatic t_mode_rsvd();
        run_op("R6", 32'h3000_0000, 2'b00, 12'h0FC, 32'h0, 2'd0, 1'b0, 2'b11);
    endtask

    task automatic t_sources();
        // same index, each source code: imm, idx, idx<<2, reserved (= idx)
        run_op("R7", 32'h100, 2'b00, 12'hFFF, 32'h10, 2'd2, 1'b0, 2'b00);
        chk("R7", "imm zero-extended", rsp_addr, 32'h0000_10FF);
        run_op("R7", 32'h100, 2'b01, 12'hFFF, 32'h10, 2'd2, 1'b0, 2'b00);
        chk("R7", "plain index", rsp_addr, 32'h0000_0110);
        run_op("R7", 32'h100, 2'b10, 12'hFFF, 32'h10, 2'd2, 1'b0, 2'b00);
        chk("R7", "shifted index", rsp_addr, 32'h0000_0140);
        run_op("R7", 32'h100, 2'b11, 12'hFFF, 32'h10, 2'd2, 1'b0, 2'b00);
        chk("R7", "reserved source", rsp_addr, 32'h0000_0110);
    endtask

    task automatic t_shift_discard();
        issue(32'h0, 2'b10, 12'h0, 32'hC000_0001, 2'd3, 1'b0, 2'b00);
        chk("R8", "shift by 3 drops top bits", rsp_addr, 32'h0000_0008);
        issue(32'h0, 2'b10, 12'h0, 32'hFFFF_FFFF, 2'd1, 1'b0, 2'b00);
        chk("R8", "shift by 1 fills zero", rsp_addr, 32'hFFFF_FFFE);
    endtask

    task automatic t_wrap();
        issue(32'hFFFF_FFF0, 2'b00, 12'h020, 32'h0, 2'd0, 1'b0, 2'b01);
        chk("R9", "add wraps", rsp_addr, 32'h0000_0010);
        issue(32'h0000_0004, 2'b00, 12'h008, 32'h0, 2'd0, 1'b1, 2'b10);
        chk("R9", "subtract wraps", rsp_base, 32'hFFFF_FFFC);
        chk("R9", "post address unchanged", rsp_addr, 32'h0000_0004);
    endtask

    task automatic t_hold_and_pulse();
        issue(32'h5000_0000, 2'b00, 12'h00C, 32'h0, 2'd0, 1'b0, 2'b01);
        // change fields with req_valid low; outputs must not move
        @(negedge clk);
        req_base = 32'hDEAD_0000; req_mode = 2'b00; req_imm = 12'h777;
        @(negedge clk);
        chk("R2", "rsp_valid low when idle", {31'd0, rsp_valid}, 32'd0);
        chk("R2", "addr held", rsp_addr, 32'h5000_000C);
        chk("R2", "base held", rsp_base, 32'h5000_000C);
        chk("R2", "wb held", {31'd0, rsp_wb}, 32'd1);
        // two back-to-back requests give two consecutive valid cycles
        @(negedge clk);
        req_base = 32'h10; req_osrc = 2'b00; req_imm = 12'h1; req_sub = 1'b0;
        req_mode = 2'b00; req_valid = 1'b1;
        @(negedge clk);
        chk("R2", "first pulse", {31'd0, rsp_valid}, 32'd1);
        req_base = 32'h20;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "second pulse", {31'd0, rsp_valid}, 32'd1);
        chk("R2", "second result", rsp_addr, 32'h21);
        @(negedge clk);
        chk("R2", "pulse ends", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_offset_mode();
        t_pre_mode();
        t_post_mode();
        t_mode_rsvd();
        t_sources();
        t_shift_discard();
        t_wrap();
        t_hold_and_pulse();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule